// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and calendar state as eight BCD registers: hundredths, seconds, minutes, hours, weekday, date, month and two-digit year. A 100 Hz enable pulse (`tick`) advances the hundredths. Each roll-over is carried to the next register, one register per clock cycle, by a small sequencer. A host transfer engine writes all eight registers in one cycle through a parallel load port. It reads all eight at any time on a 64-bit read bus. Byte *n* of each bus is register *n*: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday/control, 5 date, 6 month, 7 year.

The hours register selects its own format. With bit 7 set, hours count 01 to 12 and bit 5 is a PM flag. With bit 7 clear, hours count 00 to 23 and bit 5 is the tens-of-hours "2" digit. The weekday register holds two control bits. Bit 5 stops timekeeping when set, and bit 4 is a reset-enable flag that the surrounding logic uses. Both control bits are brought out as pins.

The carry sequencer has seven states:
- `ST_IDLE` waits for a tick.
- `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DATE` (weekday and date together), `ST_MONTH` and `ST_YEAR` each step one register.

Transitions:
- `ST_IDLE` moves to `ST_SEC` when an accepted tick wraps the hundredths.
- Each stepping state moves to the next state when its register wraps, and back to `ST_IDLE` otherwise.
- `ST_YEAR` always returns to `ST_IDLE`.
- A load sends any state to `ST_IDLE`.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the read bus shows hundredths, seconds, minutes and hours 00 in 24-hour mode, weekday byte 0x31 (stop bit 5 = 1, reset-enable bit 4 = 1, weekday 1), date 01, month 01, year 00. Both `osc_stopped` and `reset_armed` are 1.
- R2: On the rising edge that samples `tick` high while bit 5 of byte 4 is 0 and the sequencer is idle, hundredths advance by one in BCD. 99 becomes 00 and carries into seconds.
- R3: Seconds and minutes count 00 to 59 in BCD. 59 becomes 00 and carries into the next register.
- R4: In 24-hour mode (hours bit 7 = 0; bits 5:4 tens, bits 3:0 units) hours count 00 to 23. 23 becomes 00 and advances weekday and date.
- R5: In 12-hour mode (hours bit 7 = 1, bit 5 = PM, bit 4 tens, bits 3:0 units), 11 becomes 12 and toggles PM, and 12 becomes 01. Weekday and date advance only when 11 PM becomes 12 AM.
- R6: Weekday (byte 4 bits 2:0) counts 1 to 7 and wraps to 1. It advances in the same step as the date, and the two control bits are unchanged.
- R7: The date wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in 04, 06, 09 and 11. In February it wraps after 29 when the year is divisible by four, and after 28 otherwise. The date wrap carries into the month.
- R8: Month 12 becomes 01 and carries into the year. Year 99 becomes 00.
- R9: While byte 4 bit 5 is 1, ticks are ignored and no register changes.
- R10: A load writes all eight registers on the next edge and wins over a tick in the same cycle. It also cancels any carry still in progress.
- R11: Bits with no function read 0 whatever is loaded. The kept-bit masks per byte 0..7 are FF, 7F, 7F, BF, 37, 3F, 1F, FF. `osc_stopped` and `reset_armed` show byte 4 bits 5 and 4.
- R12: A loaded value at or above its register's maximum code rolls to the register's minimum and carries, instead of sticking. This holds for out-of-range BCD too.
- R13: A carry reaches the next register one cycle after the register below it wraps, so the year updates six cycles after the hundredths. A tick that arrives while a carry is in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | 64 | Eight register bytes to load, byte n = register n |
| rd_data | output | 64 | Current eight register bytes |
| osc_stopped | output | 1 | Timekeeping stop flag (byte 4 bit 5) |
| reset_armed | output | 1 | Reset-enable flag (byte 4 bit 4) |

## Verification
The bench sweeps every hundredths, second, minute and hour value into its carry, in both hour formats with both PM states. It also sweeps every month-end across leap and common years against an arithmetic calendar model.

Each corner case targets a specific fault:
- The 11 PM to 12 AM case catches a counter that advances the date at noon, or when passing 12 to 01.
- The year-end case catches a carry chain that stops early.
- Out-of-range loaded codes catch counters that lock up on illegal BCD.
- Ticks arriving mid-carry and loads colliding with ticks or with a carry catch sequencers that double-count or let a stale carry overwrite freshly loaded time.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NREG  = 8;
    localparam int BW    = 8;
    localparam int BUS_W = NREG * BW;

    localparam int R_HUND = 0;
    localparam int R_SEC  = 1;
    localparam int R_MIN  = 2;
    localparam int R_HOUR = 3;
    localparam int R_DAY  = 4;
    localparam int R_DATE = 5;
    localparam int R_MON  = 6;
    localparam int R_YEAR = 7;

    localparam int HR_MODE_BIT   = 7;
    localparam int HR_PM_BIT     = 5;
    localparam int DAY_STOP_BIT  = 5;
    localparam int DAY_RSTEN_BIT = 4;
    localparam int DAY_FIELD_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DATE,
        ST_MONTH,
        ST_YEAR
    } seq_state_t;

    // bits that hold information in each register
    function automatic logic [BW-1:0] reg_mask(input int idx);
        case (idx)
            R_SEC, R_MIN: return 8'h7F;
            R_HOUR:       return 8'hBF;
            R_DAY:        return 8'h37;
            R_DATE:       return 8'h3F;
            R_MON:        return 8'h1F;
            default:      return 8'hFF;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] bus_mask();
        logic [BUS_W-1:0] m;
        for (int i = 0; i < NREG; i++) begin
            m[i*BW +: BW] = reg_mask(i);
        end
        return m;
    endfunction

    // largest legal code of a fixed-range register
    function automatic logic [BW-1:0] field_max(input int idx);
        case (idx)
            R_SEC, R_MIN: return 8'h59;
            R_DAY:        return 8'h07;
            R_MON:        return 8'h12;
            default:      return 8'h99;
        endcase
    endfunction

    function automatic logic [BW-1:0] field_min(input int idx);
        case (idx)
            R_DAY, R_MON, R_DATE: return 8'h01;
            default:              return 8'h00;
        endcase
    endfunction

    localparam logic [BUS_W-1:0] RESET_IMAGE = {8'h00, 8'h01, 8'h01, 8'h31, 32'h0000_0000};

endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] max_i,
    input  logic [W-1:0] min_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    localparam int LO = 4;

    always_comb begin
        wrap_o = 1'b0;
        val_o  = val_i;
        if (val_i >= max_i) begin
            // at or past the top code, including illegal BCD: restart
            val_o  = min_i;
            wrap_o = 1'b1;
        end else if (val_i[LO-1:0] >= 4'd9) begin
            val_o = {val_i[W-1:LO] + 1'b1, {LO{1'b0}}};
        end else begin
            val_o = {val_i[W-1:LO], val_i[LO-1:0] + 1'b1};
        end
    end
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
    import cal_pkg::*;
(
    input  logic [BW-1:0] hr_i,
    output logic [BW-1:0] hr_o,
    output logic          carry_o
);
    logic          mode12;
    logic          pm;
    logic [BW-1:0] f24_in, f24_out;
    logic [BW-1:0] f12_in, f12_out;
    logic          w24, w12;
    logic          spare_unused;

    assign mode12 = hr_i[HR_MODE_BIT];
    assign pm     = hr_i[HR_PM_BIT];
    assign f24_in = {2'b00, hr_i[5:0]};
    assign f12_in = {3'b000, hr_i[4:0]};

    cal_bcd_step #(.W(BW)) u_h24 (
        .val_i (f24_in),
        .max_i (8'h23),
        .min_i (8'h00),
        .val_o (f24_out),
        .wrap_o(w24)
    );

    cal_bcd_step #(.W(BW)) u_h12 (
        .val_i (f12_in),
        .max_i (8'h12),
        .min_i (8'h01),
        .val_o (f12_out),
        .wrap_o(w12)
    );

    assign spare_unused = ^{hr_i[6], f12_out[7:5], f24_out[7:6], w12};

    always_comb begin
        if (mode12) begin
            if (f12_in == 8'h11) begin
                hr_o    = {1'b1, 1'b0, ~pm, 5'h12};
                carry_o = pm;
            end else begin
                hr_o    = {1'b1, 1'b0, pm, f12_out[4:0]};
                carry_o = 1'b0;
            end
        end else begin
            hr_o    = {2'b00, f24_out[5:0]};
            carry_o = w24;
        end
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  logic [BW-1:0] mon_i,
    input  logic [BW-1:0] yr_i,
    output logic [BW-1:0] last_date_o
);
    logic leap;
    logic spare_unused;

    // BCD year divisible by four: even tens need units 0/4/8, odd tens need 2/6
    assign leap = yr_i[4] ? (yr_i[1:0] == 2'b10) : (yr_i[1:0] == 2'b00);
    assign spare_unused = ^{yr_i[7:5], yr_i[3:2]};

    always_comb begin
        case (mon_i)
            8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
            default:                    last_date_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/cal_fsm.sv
module cal_fsm
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ok,
    input  logic load_en,
    input  logic carry_cur,
    output logic step_hund,
    output logic step_sec,
    output logic step_min,
    output logic step_hour,
    output logic step_cal,
    output logic step_mon,
    output logic step_year,
    output logic idle
);
    seq_state_t state, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  state_d = (tick_ok && carry_cur) ? ST_SEC : ST_IDLE;
            ST_SEC:   state_d = carry_cur ? ST_MIN   : ST_IDLE;
            ST_MIN:   state_d = carry_cur ? ST_HOUR  : ST_IDLE;
            ST_HOUR:  state_d = carry_cur ? ST_DATE  : ST_IDLE;
            ST_DATE:  state_d = carry_cur ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_d = carry_cur ? ST_YEAR  : ST_IDLE;
            ST_YEAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (load_en) begin
            state_d = ST_IDLE;
        end
    end

    always_comb begin
        step_hund = 1'b0;
        step_sec  = 1'b0;
        step_min  = 1'b0;
        step_hour = 1'b0;
        step_cal  = 1'b0;
        step_mon  = 1'b0;
        step_year = 1'b0;
        idle      = (state == ST_IDLE);
        if (!load_en) begin
            unique case (state)
                ST_IDLE:  step_hund = tick_ok;
                ST_SEC:   step_sec  = 1'b1;
                ST_MIN:   step_min  = 1'b1;
                ST_HOUR:  step_hour = 1'b1;
                ST_DATE:  step_cal  = 1'b1;
                ST_MONTH: step_mon  = 1'b1;
                ST_YEAR:  step_year = 1'b1;
                default:  step_hund = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [BUS_W-1:0] load_data,
    output logic [BUS_W-1:0] rd_data,
    output logic             osc_stopped,
    output logic             reset_armed
);
    logic [NREG-1:0][BW-1:0] regs_q;
    logic [NREG-1:0][BW-1:0] step_v;
    logic [NREG-1:0]         wrap_v;
    logic tick_ok, carry_cur, seq_idle;
    logic step_hund, step_sec, step_min, step_hour, step_cal, step_mon, step_year;
    logic spare_unused;

    assign osc_stopped = regs_q[R_DAY][DAY_STOP_BIT];
    assign reset_armed = regs_q[R_DAY][DAY_RSTEN_BIT];
    assign tick_ok     = tick & ~osc_stopped;
    assign rd_data     = regs_q;

    for (genvar g = 0; g < NREG; g++) begin : g_stage
        if (g == R_HOUR) begin : g_hour
            cal_hour_step u_hour (
                .hr_i   (regs_q[g]),
                .hr_o   (step_v[g]),
                .carry_o(wrap_v[g])
            );
        end else if (g == R_DAY) begin : g_day
            logic [BW-1:0] day_in, day_out;
            logic          day_wrap_unused;
            logic          day_spare_unused;
            assign day_in = {{(BW-DAY_FIELD_W){1'b0}}, regs_q[g][DAY_FIELD_W-1:0]};
            cal_bcd_step #(.W(BW)) u_day (
                .val_i (day_in),
                .max_i (field_max(g)),
                .min_i (field_min(g)),
                .val_o (day_out),
                .wrap_o(day_wrap_unused)
            );
            assign step_v[g] = {2'b00, regs_q[g][DAY_STOP_BIT], regs_q[g][DAY_RSTEN_BIT],
                                1'b0, day_out[DAY_FIELD_W-1:0]};
            assign wrap_v[g] = 1'b0;
            assign day_spare_unused = ^day_out[BW-1:DAY_FIELD_W];
        end else if (g == R_DATE) begin : g_date
            logic [BW-1:0] last_date;
            cal_month_len u_len (
                .mon_i      (regs_q[R_MON]),
                .yr_i       (regs_q[R_YEAR]),
                .last_date_o(last_date)
            );
            cal_bcd_step #(.W(BW)) u_date (
                .val_i (regs_q[g]),
                .max_i (last_date),
                .min_i (field_min(g)),
                .val_o (step_v[g]),
                .wrap_o(wrap_v[g])
            );
        end else begin : g_plain
            cal_bcd_step #(.W(BW)) u_cnt (
                .val_i (regs_q[g]),
                .max_i (field_max(g)),
                .min_i (field_min(g)),
                .val_o (step_v[g]),
                .wrap_o(wrap_v[g])
            );
        end
    end

    assign spare_unused = wrap_v[R_DAY];

    assign carry_cur = (step_hund & wrap_v[R_HUND]) | (step_sec  & wrap_v[R_SEC])
                     | (step_min  & wrap_v[R_MIN])  | (step_hour & wrap_v[R_HOUR])
                     | (step_cal  & wrap_v[R_DATE]) | (step_mon  & wrap_v[R_MON])
                     | (step_year & wrap_v[R_YEAR]);

    cal_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ok  (tick_ok),
        .load_en  (load_en),
        .carry_cur(carry_cur),
        .step_hund(step_hund),
        .step_sec (step_sec),
        .step_min (step_min),
        .step_hour(step_hour),
        .step_cal (step_cal),
        .step_mon (step_mon),
        .step_year(step_year),
        .idle     (seq_idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= RESET_IMAGE;
        end else if (load_en) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= load_data[i*BW +: BW] & reg_mask(i);
            end
        end else begin
            if (step_hund) regs_q[R_HUND] <= step_v[R_HUND];
            if (step_sec)  regs_q[R_SEC]  <= step_v[R_SEC];
            if (step_min)  regs_q[R_MIN]  <= step_v[R_MIN];
            if (step_hour) regs_q[R_HOUR] <= step_v[R_HOUR];
            if (step_cal) begin
                regs_q[R_DAY]  <= step_v[R_DAY];
                regs_q[R_DATE] <= step_v[R_DATE];
            end
            if (step_mon)  regs_q[R_MON]  <= step_v[R_MON];
            if (step_year) regs_q[R_YEAR] <= step_v[R_YEAR];
        end
    end
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk
    import cal_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [BUS_W-1:0] load_data,
    input logic [BUS_W-1:0] rd_data,
    input logic             osc_stopped,
    input logic             seq_idle
);
    localparam logic [BUS_W-1:0] KEEP = bus_mask();

    logic [BW-1:0]          date_f;
    logic [DAY_FIELD_W-1:0] day_f;
    assign date_f = rd_data[R_DATE*BW +: BW];
    assign day_f  = rd_data[R_DAY*BW +: DAY_FIELD_W];

    // R9: a stopped, idle counter keeps every register
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stopped && seq_idle && !load_en) |=> (rd_data == $past(rd_data)));

    // R10: a load lands on the next edge, masked
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (rd_data == ($past(load_data) & KEEP)));

    // R11: bits with no function read zero
    p_zero_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~KEEP) == '0));

    // R13: while a carry is in progress the hundredths are frozen
    p_busy_drop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && !load_en) |=> (rd_data[R_HUND*BW +: BW] == $past(rd_data[R_HUND*BW +: BW])));

    // R6: a date step always moves the weekday too
    p_day_with_date_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((date_f != $past(date_f)) && !$past(load_en)) |-> (day_f != $past(day_f)));
endmodule

bind bcd_calendar_counter cal_counter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_data  (load_data),
    .rd_data    (rd_data),
    .osc_stopped(osc_stopped),
    .seq_idle   (seq_idle)
);

// File: tb/bcd_calendar_counter_tb.sv
module bcd_calendar_counter_tb;

    localparam logic [63:0] KEEP      = 64'hFF1F_3F37_BF7F_7FFF;
    localparam logic [63:0] RST_IMAGE = 64'h0001_0131_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] rd_data;
    logic        osc_stopped, reset_armed;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar_counter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (load_en),
        .load_data  (load_data),
        .rd_data    (rd_data),
        .osc_stopped(osc_stopped),
        .reset_armed(reset_armed)
    );

    function automatic logic [7:0] bb(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int ib(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] pk(input int yr, input int mo, input int dt,
                                       input logic [7:0] dayb, input logic [7:0] hrb,
                                       input int mn, input int sc, input int hu);
        return {bb(yr), bb(mo), bb(dt), dayb, hrb, bb(mn), bb(sc), bb(hu)};
    endfunction

    // arithmetic calendar model for legal register contents
    function automatic logic [63:0] ref_next(input logic [63:0] c);
        int hu, sc, mn, hr, dw, dt, mo, yr;
        bit m12, pm, cy;
        logic [7:0] hb, db, hbcd;
        hb = c[31:24];
        db = c[39:32];
        if (db[5]) return c;
        hu  = ib(c[7:0]);
        sc  = ib(c[15:8]);
        mn  = ib(c[23:16]);
        m12 = hb[7];
        pm  = hb[5];
        hr  = m12 ? ib({3'b000, hb[4:0]}) : ib({2'b00, hb[5:0]});
        dw  = int'(db[2:0]);
        dt  = ib(c[47:40]);
        mo  = ib(c[55:48]);
        yr  = ib(c[63:56]);
        cy  = 1'b0;
        hu++;
        if (hu == 100) begin
            hu = 0; sc++;
            if (sc == 60) begin
                sc = 0; mn++;
                if (mn == 60) begin
                    mn = 0;
                    if (m12) begin
                        if (hr == 11) begin hr = 12; cy = pm; pm = !pm; end
                        else if (hr == 12) hr = 1;
                        else hr++;
                    end else begin
                        hr++;
                        if (hr == 24) begin hr = 0; cy = 1'b1; end
                    end
                end
            end
        end
        if (cy) begin
            dw = (dw == 7) ? 1 : dw + 1;
            dt++;
            if (dt > days_in(mo, yr)) begin
                dt = 1; mo++;
                if (mo > 12) begin mo = 1; yr = (yr + 1) % 100; end
            end
        end
        hbcd = bb(hr);
        hb   = m12 ? {1'b1, 1'b0, pm, hbcd[4:0]} : {2'b00, hbcd[5:0]};
        db   = {db[7:3], 3'(dw)};
        return {bb(yr), bb(mo), bb(dt), db, hb, bb(mn), bb(sc), bb(hu)};
    endfunction

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] v);
        @(negedge clk);
        load_en = 1'b1;
        load_data = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic do_tick(input int width);
        @(negedge clk);
        tick = 1'b1;
        repeat (width) @(negedge clk);
        tick = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic tick_check(input string tag, input logic [63:0] start);
        logic [63:0] exp;
        do_load(start);
        exp = ref_next(start & KEEP);
        do_tick(1);
        chk64(tag, rd_data, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [63:0] cur;
        logic [63:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset image
        chk64("R1 reset image", rd_data, RST_IMAGE);
        chk1("R1 osc_stopped", osc_stopped, 1'b1);
        chk1("R1 reset_armed", reset_armed, 1'b1);

        // R9 ticks ignored while stopped
        do_tick(1);
        chk64("R9 stopped after reset", rd_data, RST_IMAGE);
        do_load(pk(24, 6, 15, 8'h23, 8'h10, 59, 59, 99));
        do_tick(1);
        chk64("R9 stopped with carry pending", rd_data, pk(24, 6, 15, 8'h23, 8'h10, 59, 59, 99));

        // R2 full hundredths sweep
        cur = pk(24, 6, 15, 8'h03, 8'h10, 30, 20, 0);
        do_load(cur);
        for (int k = 0; k < 100; k++) begin
            exp = ref_next(cur);
            do_tick(1);
            chk64("R2 hundredths", rd_data, exp);
            cur = exp;
        end

        // R3 seconds and minutes
        for (int s = 0; s < 60; s++)
            tick_check("R3 seconds", pk(24, 6, 15, 8'h03, 8'h10, 30, s, 99));
        for (int m = 0; m < 60; m++)
            tick_check("R3 minutes", pk(24, 6, 15, 8'h03, 8'h10, m, 59, 99));

        // R4 24-hour mode
        for (int h = 0; h < 24; h++)
            tick_check("R4 hours24", pk(24, 6, 15, 8'h03, bb(h), 59, 59, 99));

        // R5 12-hour mode, both halves of the day
        for (int p = 0; p < 2; p++)
            for (int h = 1; h <= 12; h++)
                tick_check("R5 hours12",
                    pk(24, 6, 15, 8'h03, 8'h80 | (p != 0 ? 8'h20 : 8'h00) | bb(h), 59, 59, 99));
        do_load(pk(24, 6, 15, 8'h03, 8'hB1, 59, 59, 99));
        do_tick(1);
        chk64("R5 11PM to 12AM", rd_data, pk(24, 6, 16, 8'h04, 8'h92, 0, 0, 0));
        do_load(pk(24, 6, 15, 8'h03, 8'h91, 59, 59, 99));
        do_tick(1);
        chk64("R5 11AM to 12PM", rd_data, pk(24, 6, 15, 8'h03, 8'hB2, 0, 0, 0));

        // R6 weekday wrap, control bits untouched
        for (int d = 1; d <= 7; d++)
            tick_check("R6 weekday", pk(24, 6, 10, 8'(d), 8'h23, 59, 59, 99));
        do_load(pk(24, 6, 10, 8'h17, 8'h23, 59, 59, 99));
        do_tick(1);
        chk64("R6 weekday 7 with reset-enable", rd_data, pk(24, 6, 11, 8'h11, 8'h00, 0, 0, 0));

        // R7 month ends across common and leap years
        for (int mo = 1; mo <= 12; mo++) begin
            for (int yi = 0; yi < 5; yi++) begin
                int yr;
                yr = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 4 : (yi == 3) ? 38 : 96;
                tick_check("R7 month end", pk(yr, mo, days_in(mo, yr), 8'h02, 8'h23, 59, 59, 99));
            end
        end
        do_load(pk(4, 2, 28, 8'h02, 8'h23, 59, 59, 99));
        do_tick(1);
        chk64("R7 leap Feb 28", rd_data, pk(4, 2, 29, 8'h03, 8'h00, 0, 0, 0));
        do_load(pk(1, 2, 28, 8'h02, 8'h23, 59, 59, 99));
        do_tick(1);
        chk64("R7 common Feb 28", rd_data, pk(1, 3, 1, 8'h03, 8'h00, 0, 0, 0));

        // R8 year end
        do_load(pk(99, 12, 31, 8'h05, 8'h23, 59, 59, 99));
        do_tick(1);
        chk64("R8 year end", rd_data, pk(0, 1, 1, 8'h06, 8'h00, 0, 0, 0));

        // R10 load in the same cycle as a tick
        do_load(pk(50, 5, 5, 8'h01, 8'h05, 5, 5, 5));
        @(negedge clk);
        tick = 1'b1; load_en = 1'b1;
        load_data = pk(10, 3, 3, 8'h02, 8'h05, 4, 4, 4);
        @(negedge clk);
        tick = 1'b0; load_en = 1'b0;
        repeat (8) @(negedge clk);
        chk64("R10 load beats tick", rd_data, pk(10, 3, 3, 8'h02, 8'h05, 4, 4, 4));

        // R10 load cancels a carry in progress
        do_load(pk(99, 12, 31, 8'h05, 8'h23, 59, 59, 99));
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        load_en = 1'b1;
        load_data = pk(10, 3, 3, 8'h02, 8'h05, 4, 4, 4);
        @(negedge clk);
        load_en = 1'b0;
        repeat (8) @(negedge clk);
        chk64("R10 load cancels carry", rd_data, pk(10, 3, 3, 8'h02, 8'h05, 4, 4, 4));

        // R11 unused bits and control outputs
        do_load(64'hFFFF_FFFF_FFFF_FFFF);
        chk64("R11 masked all-ones", rd_data, KEEP);
        chk1("R11 osc_stopped set", osc_stopped, 1'b1);
        chk1("R11 reset_armed set", reset_armed, 1'b1);
        do_load(64'h0001_0101_0000_0000);
        chk1("R11 osc_stopped clear", osc_stopped, 1'b0);
        chk1("R11 reset_armed clear", reset_armed, 1'b0);

        // R12 out-of-range codes roll to their minimum
        do_load({8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h10, 8'hAB});
        do_tick(1);
        chk64("R12 hundredths AB", rd_data, {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h11, 8'h00});
        do_load({8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h7A, 8'h99});
        do_tick(1);
        chk64("R12 seconds 7A", rd_data, {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00});
        do_load({8'h07, 8'h04, 8'h35, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99});
        do_tick(1);
        chk64("R12 April 35", rd_data, {8'h07, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00});
        do_load({8'h07, 8'h04, 8'h10, 8'h02, 8'h95, 8'h59, 8'h59, 8'h99});
        do_tick(1);
        chk64("R12 12h hour 15", rd_data, {8'h07, 8'h04, 8'h10, 8'h02, 8'h81, 8'h00, 8'h00, 8'h00});

        // R13 tick during a carry is dropped, plain ticks each count
        do_load(pk(20, 1, 1, 8'h01, 8'h00, 0, 0, 99));
        do_tick(2);
        chk64("R13 tick during carry dropped", rd_data, pk(20, 1, 1, 8'h01, 8'h00, 0, 1, 0));
        do_load(pk(20, 1, 1, 8'h01, 8'h00, 0, 0, 5));
        do_tick(2);
        chk64("R13 two idle ticks", rd_data, pk(20, 1, 1, 8'h01, 8'h00, 0, 0, 7));

        // R13 carry timing: year lands six cycles after hundredths
        do_load(pk(99, 12, 31, 8'h05, 8'h23, 59, 59, 99));
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk64("R13 hundredths first", rd_data[7:0], 64'h00);
        chk64("R13 year not yet", rd_data[63:56], 64'h99);
        repeat (5) @(negedge clk);
        chk64("R13 year before last stage", rd_data[63:56], 64'h99);
        @(negedge clk);
        chk64("R13 year after six stages", rd_data[63:56], 64'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule